// File: doc/BRIEF.md
# Register Result Status Rename Table

This block keeps, for every architectural register, a record of which in-flight producer (a reservation station or load buffer, identified by a tag) will deliver that register's next value. When the slot is empty, the value held in the attached register file is current. The table holds both the status entries and the register values.

At issue, the block does three things. Two source lookups return either the register value or the tag of the pending producer that the reservation station must wait for. One destination rename then overwrites that register's status with the issuing instruction's tag. Renaming the same register again in later loop iterations simply replaces the tag, so each iteration is bound to its own producer.

The block also watches the shared result bus, which carries at most one result per cycle. A broadcast updates a register only while that register's status still holds the broadcast tag. A result from a producer that has since been superseded therefore never reaches the register file, and write-after-write ordering is preserved without stalls. An optional debug port reads and writes register values directly.

Top module: `rename_status_table`

## Requirements
- R1: After reset every status entry is empty and every register value is zero. Every lookup returns pending = 0 and value = 0.
- R2: A source lookup of a register whose status is empty returns pending = 0 and the stored register value, combinationally in the same cycle.
- R3: A source lookup of a register whose status is busy returns pending = 1 and the producer tag held in the status, unless R8 applies.
- R4: A rename (ren_en = 1) sets the named register's status to busy with ren_tag from the next clock edge. This happens even if the register was already busy with another tag, which is overwritten.
- R5: A bus result (bus_vld = 1) whose tag equals a busy register's status tag writes bus_data into that register and clears its status to empty at the same clock edge.
- R6: A bus result whose tag does not match a register's status leaves that register's value and status unchanged, so stale results from overwritten producers are discarded.
- R7: When a rename and a matching bus result hit the same register in one cycle, the status takes the new rename tag (the rename wins). The register value still receives the bus data.
- R8: When a source lookup hits a busy register whose tag equals the tag on the bus in the same cycle, the lookup returns pending = 0 and bus_data instead of the tag.
- R9: With the debug port enabled, dbg_rdata returns the stored value of register dbg_idx combinationally. A debug write changes the value at the next edge and leaves the status unchanged. A matching bus result to the same register in the same cycle takes precedence over the debug write.
- R10: The two source lookup ports are independent. Both may name the same register, or different ones, in the same cycle and each returns its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_idx | input | IDX_W | Register index for source lookup A |
| src_a_pend | output | 1 | Source A must wait for a producer |
| src_a_tag | output | TAG_W | Producer tag for source A when pending |
| src_a_val | output | DATA_W | Operand value for source A when not pending |
| src_b_idx | input | IDX_W | Register index for source lookup B |
| src_b_pend | output | 1 | Source B must wait for a producer |
| src_b_tag | output | TAG_W | Producer tag for source B when pending |
| src_b_val | output | DATA_W | Operand value for source B when not pending |
| ren_en | input | 1 | Record a new producer for a destination register |
| ren_idx | input | IDX_W | Destination register being renamed |
| ren_tag | input | TAG_W | Tag of the new producer |
| bus_vld | input | 1 | Result bus carries a result this cycle |
| bus_tag | input | TAG_W | Tag of the producer broadcasting |
| bus_data | input | DATA_W | Broadcast result value |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_idx | input | IDX_W | Debug register index |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rdata | output | DATA_W | Debug read data |

## Verification
The lookup results (R2, R3, R8, R10) and the debug read are combinational. The bench therefore drives inputs just after a falling edge and samples a quarter period later, before the next rising edge. Renames, bus write-backs and debug writes (R4 to R7, R9) take effect at the next rising edge. Their checks are made after the following falling edge, by which point stimulus has been withdrawn, so exactly one edge separates cause and observation. Discarded results (R6) and the value side of the rename collision (R7) are observed through the lookup and debug read ports in that following cycle.

// File: rtl/rst_pkg.sv
package rst_pkg;

   // index width that stays legal for a single-entry table
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // where a lookup result came from
   typedef enum logic [1:0] {
      SRC_FILE = 2'd0,
      SRC_BUS  = 2'd1,
      SRC_WAIT = 2'd2
   } src_origin_e;

endpackage

// File: rtl/rst_status_array.sv
module rst_status_array #(
   parameter int NUM_REGS = 16,
   parameter int TAG_W    = 4,
   localparam int IDX_W   = rst_pkg::idx_width(NUM_REGS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ren_en,
   input  logic [IDX_W-1:0]                ren_idx,
   input  logic [TAG_W-1:0]                ren_tag,
   input  logic                            bus_vld,
   input  logic [TAG_W-1:0]                bus_tag,
   output logic [NUM_REGS-1:0]             busy_q,
   output logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q,
   output logic [NUM_REGS-1:0]             hit_vec
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
      logic ren_here;

      assign ren_here   = ren_en && (ren_idx == IDX_W'(i));
      assign hit_vec[i] = bus_vld && busy_q[i] && (tag_q[i] == bus_tag);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q[i] <= 1'b0;
            tag_q[i]  <= '0;
         end else if (ren_here) begin
            // a new producer supersedes any result arriving now
            busy_q[i] <= 1'b1;
            tag_q[i]  <= ren_tag;
         end else if (hit_vec[i]) begin
            busy_q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rst_value_file.sv
module rst_value_file #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter bit DBG_EN   = 1'b1,
   localparam int IDX_W   = rst_pkg::idx_width(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_REGS-1:0]              hit_vec,
   input  logic [DATA_W-1:0]                bus_data,
   input  logic                             dbg_wr_en,
   input  logic [IDX_W-1:0]                 dbg_idx,
   input  logic [DATA_W-1:0]                dbg_wdata,
   output logic [DATA_W-1:0]                dbg_rdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  val_q
);

   logic [NUM_REGS-1:0] dbg_sel;

   if (DBG_EN) begin : g_dbg
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
         assign dbg_sel[i] = dbg_wr_en && (dbg_idx == IDX_W'(i));
      end
      assign dbg_rdata = val_q[dbg_idx];
   end else begin : g_nodbg
      logic unused_dbg;
      assign unused_dbg = ^{dbg_wr_en, dbg_idx, dbg_wdata};
      assign dbg_sel    = '0;
      assign dbg_rdata  = '0;
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q[i] <= '0;
         end else if (hit_vec[i]) begin
            val_q[i] <= bus_data;
         end else if (dbg_sel[i]) begin
            val_q[i] <= dbg_wdata;
         end
      end
   end

endmodule

// File: rtl/rst_src_lookup.sv
module rst_src_lookup #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   localparam int IDX_W   = rst_pkg::idx_width(NUM_REGS)
) (
   input  logic [IDX_W-1:0]                 idx,
   input  logic [NUM_REGS-1:0]              busy_q,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_q,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_q,
   input  logic                             bus_vld,
   input  logic [TAG_W-1:0]                 bus_tag,
   input  logic [DATA_W-1:0]                bus_data,
   output logic                             pend,
   output logic [TAG_W-1:0]                 tag,
   output logic [DATA_W-1:0]                val
);

   rst_pkg::src_origin_e origin;
   logic                 ent_busy;
   logic [TAG_W-1:0]     ent_tag;

   assign ent_busy = busy_q[idx];
   assign ent_tag  = tag_q[idx];

   always_comb begin
      if (!ent_busy)
         origin = rst_pkg::SRC_FILE;
      else if (bus_vld && (bus_tag == ent_tag))
         origin = rst_pkg::SRC_BUS;
      else
         origin = rst_pkg::SRC_WAIT;
   end

   always_comb begin
      pend = 1'b0;
      tag  = ent_tag;
      val  = val_q[idx];
      unique case (origin)
         rst_pkg::SRC_FILE: val  = val_q[idx];
         rst_pkg::SRC_BUS:  val  = bus_data;
         rst_pkg::SRC_WAIT: pend = 1'b1;
         default:           pend = 1'b1;
      endcase
   end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   parameter bit DBG_EN   = 1'b1,
   localparam int IDX_W   = rst_pkg::idx_width(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  src_a_idx,
   output logic              src_a_pend,
   output logic [TAG_W-1:0]  src_a_tag,
   output logic [DATA_W-1:0] src_a_val,
   input  logic [IDX_W-1:0]  src_b_idx,
   output logic              src_b_pend,
   output logic [TAG_W-1:0]  src_b_tag,
   output logic [DATA_W-1:0] src_b_val,
   input  logic              ren_en,
   input  logic [IDX_W-1:0]  ren_idx,
   input  logic [TAG_W-1:0]  ren_tag,
   input  logic              bus_vld,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              dbg_wr_en,
   input  logic [IDX_W-1:0]  dbg_idx,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic [DATA_W-1:0] dbg_rdata
);

   localparam int NUM_SRC = 2;

   if (NUM_REGS < 2)  begin : g_bad_regs  $error("NUM_REGS must be at least 2"); end
   if (DATA_W < 1)    begin : g_bad_data  $error("DATA_W must be positive");     end
   if (TAG_W < 1)     begin : g_bad_tag   $error("TAG_W must be positive");      end
   if (NUM_REGS > 1024) begin : g_bad_big $error("NUM_REGS too large");          end

   logic [NUM_REGS-1:0]             busy_q;
   logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] val_q;
   logic [NUM_REGS-1:0]             hit_vec;

   rst_status_array #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .ren_en  (ren_en),
      .ren_idx (ren_idx),
      .ren_tag (ren_tag),
      .bus_vld (bus_vld),
      .bus_tag (bus_tag),
      .busy_q  (busy_q),
      .tag_q   (tag_q),
      .hit_vec (hit_vec)
   );

   rst_value_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DBG_EN(DBG_EN)) u_values (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_vec   (hit_vec),
      .bus_data  (bus_data),
      .dbg_wr_en (dbg_wr_en),
      .dbg_idx   (dbg_idx),
      .dbg_wdata (dbg_wdata),
      .dbg_rdata (dbg_rdata),
      .val_q     (val_q)
   );

   logic [NUM_SRC-1:0][IDX_W-1:0]  s_idx;
   logic [NUM_SRC-1:0]             s_pend;
   logic [NUM_SRC-1:0][TAG_W-1:0]  s_tag;
   logic [NUM_SRC-1:0][DATA_W-1:0] s_val;

   assign s_idx[0] = src_a_idx;
   assign s_idx[1] = src_b_idx;

   for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
      rst_src_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_lookup (
         .idx      (s_idx[p]),
         .busy_q   (busy_q),
         .tag_q    (tag_q),
         .val_q    (val_q),
         .bus_vld  (bus_vld),
         .bus_tag  (bus_tag),
         .bus_data (bus_data),
         .pend     (s_pend[p]),
         .tag      (s_tag[p]),
         .val      (s_val[p])
      );
   end

   assign src_a_pend = s_pend[0];
   assign src_a_tag  = s_tag[0];
   assign src_a_val  = s_val[0];
   assign src_b_pend = s_pend[1];
   assign src_b_tag  = s_tag[1];
   assign src_b_val  = s_val[1];

endmodule

// File: rtl/rename_status_table_chk.sv
module rename_status_table_chk #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   localparam int IDX_W   = rst_pkg::idx_width(NUM_REGS)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            ren_en,
   input logic [IDX_W-1:0]                ren_idx,
   input logic [TAG_W-1:0]                ren_tag,
   input logic                            bus_vld,
   input logic [TAG_W-1:0]                bus_tag,
   input logic [DATA_W-1:0]               bus_data,
   input logic [IDX_W-1:0]                src_a_idx,
   input logic                            src_a_pend,
   input logic [TAG_W-1:0]                src_a_tag,
   input logic [DATA_W-1:0]               src_a_val,
   input logic [NUM_REGS-1:0]             busy_q,
   input logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q
);

   // R4: rename takes effect at the next edge, rename wins (R7)
   a_r4_rename_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ren_en |=> (busy_q[$past(ren_idx)] && tag_q[$past(ren_idx)] == $past(ren_tag)));

   // R3: a busy source not served by the bus reports its producer
   a_r3_pending_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[src_a_idx] && !(bus_vld && bus_tag == tag_q[src_a_idx]))
      |-> (src_a_pend && src_a_tag == tag_q[src_a_idx]));

   // R8: same-cycle broadcast is forwarded to the lookup
   a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[src_a_idx] && bus_vld && bus_tag == tag_q[src_a_idx])
      |-> (!src_a_pend && src_a_val == bus_data));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      // R5: a matching broadcast empties the entry
      a_r5_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_vld && busy_q[i] && tag_q[i] == bus_tag && !(ren_en && ren_idx == IDX_W'(i)))
         |=> !busy_q[i]);

      // R6: with no rename and no matching tag the entry holds
      a_r6_entry_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!(ren_en && ren_idx == IDX_W'(i)) && !(bus_vld && busy_q[i] && tag_q[i] == bus_tag))
         |=> ($stable(busy_q[i]) && (!busy_q[i] || $stable(tag_q[i]))));
   end

endmodule

bind rename_status_table rename_status_table_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .TAG_W    (TAG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ren_en    (ren_en),
   .ren_idx   (ren_idx),
   .ren_tag   (ren_tag),
   .bus_vld   (bus_vld),
   .bus_tag   (bus_tag),
   .bus_data  (bus_data),
   .src_a_idx (src_a_idx),
   .src_a_pend(src_a_pend),
   .src_a_tag (src_a_tag),
   .src_a_val (src_a_val),
   .busy_q    (busy_q),
   .tag_q     (tag_q)
);

// File: tb/rename_status_table_bench.sv
module rename_status_table_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 16;
   localparam int DW = 32;
   localparam int TW = 4;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] src_a_idx = '0, src_b_idx = '0;
   logic          src_a_pend, src_b_pend;
   logic [TW-1:0] src_a_tag, src_b_tag;
   logic [DW-1:0] src_a_val, src_b_val;
   logic          ren_en = 1'b0;
   logic [IW-1:0] ren_idx = '0;
   logic [TW-1:0] ren_tag = '0;
   logic          bus_vld = 1'b0;
   logic [TW-1:0] bus_tag = '0;
   logic [DW-1:0] bus_data = '0;
   logic          dbg_wr_en = 1'b0;
   logic [IW-1:0] dbg_idx = '0;
   logic [DW-1:0] dbg_wdata = '0;
   logic [DW-1:0] dbg_rdata;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rename_status_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .DBG_EN(1'b1)) u_rename_status_table (
      .clk(clk), .rst_n(rst_n),
      .src_a_idx(src_a_idx), .src_a_pend(src_a_pend), .src_a_tag(src_a_tag), .src_a_val(src_a_val),
      .src_b_idx(src_b_idx), .src_b_pend(src_b_pend), .src_b_tag(src_b_tag), .src_b_val(src_b_val),
      .ren_en(ren_en), .ren_idx(ren_idx), .ren_tag(ren_tag),
      .bus_vld(bus_vld), .bus_tag(bus_tag), .bus_data(bus_data),
      .dbg_wr_en(dbg_wr_en), .dbg_idx(dbg_idx), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
   );

   task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      #(CLK_PERIOD/4);
   endtask

   task automatic next_cycle();
      @(negedge clk);
      ren_en = 1'b0; bus_vld = 1'b0; dbg_wr_en = 1'b0;
   endtask

   task automatic t_reset();
      for (int r = 0; r < NR; r += 5) begin
         src_a_idx = IW'(r); dbg_idx = IW'(r);
         settle();
         check("R1", "reset pend", DW'(src_a_pend), 0);
         check("R1", "reset value", src_a_val, 0);
         check("R1", "reset dbg", dbg_rdata, 0);
         next_cycle();
      end
   endtask

   task automatic t_debug_and_lookup();
      dbg_wr_en = 1'b1; dbg_idx = 3; dbg_wdata = 32'h1111_0003;
      next_cycle();
      dbg_idx = 3; src_a_idx = 3;
      settle();
      check("R9", "dbg read after write", dbg_rdata, 32'h1111_0003);
      check("R2", "empty lookup pend", DW'(src_a_pend), 0);
      check("R2", "empty lookup value", src_a_val, 32'h1111_0003);
      next_cycle();
   endtask

   task automatic t_rename();
      ren_en = 1'b1; ren_idx = 3; ren_tag = 5;
      next_cycle();
      src_a_idx = 3; settle();
      check("R3", "busy pend", DW'(src_a_pend), 1);
      check("R4", "first tag", DW'(src_a_tag), 5);
      ren_en = 1'b1; ren_idx = 3; ren_tag = 9;
      next_cycle();
      settle();
      check("R4", "overwritten tag", DW'(src_a_tag), 9);
      next_cycle();
   endtask

   task automatic t_stale_result();
      bus_vld = 1'b1; bus_tag = 5; bus_data = 32'hDEAD_0005;
      src_a_idx = 3; settle();
      check("R3", "stale bus not forwarded", DW'(src_a_pend), 1);
      next_cycle();
      src_a_idx = 3; dbg_idx = 3; settle();
      check("R6", "stale keeps pend", DW'(src_a_pend), 1);
      check("R6", "stale keeps tag", DW'(src_a_tag), 9);
      check("R6", "stale keeps value", dbg_rdata, 32'h1111_0003);
      next_cycle();
   endtask

   task automatic t_match_and_forward();
      bus_vld = 1'b1; bus_tag = 9; bus_data = 32'hBEEF_0009;
      src_a_idx = 3; settle();
      check("R8", "forward pend", DW'(src_a_pend), 0);
      check("R8", "forward value", src_a_val, 32'hBEEF_0009);
      next_cycle();
      src_a_idx = 3; settle();
      check("R5", "match clears", DW'(src_a_pend), 0);
      check("R5", "match writes", src_a_val, 32'hBEEF_0009);
      next_cycle();
   endtask

   task automatic t_collide();
      ren_en = 1'b1; ren_idx = 4; ren_tag = 2;
      next_cycle();
      ren_en = 1'b1; ren_idx = 4; ren_tag = 7;
      bus_vld = 1'b1; bus_tag = 2; bus_data = 32'hCAFE_0002;
      next_cycle();
      src_a_idx = 4; dbg_idx = 4; settle();
      check("R7", "rename wins pend", DW'(src_a_pend), 1);
      check("R7", "rename wins tag", DW'(src_a_tag), 7);
      check("R7", "value still written", dbg_rdata, 32'hCAFE_0002);
      next_cycle();
   endtask

   task automatic t_debug_on_busy();
      dbg_wr_en = 1'b1; dbg_idx = 4; dbg_wdata = 32'h0000_4444;
      next_cycle();
      src_a_idx = 4; dbg_idx = 4; settle();
      check("R9", "dbg write value", dbg_rdata, 32'h0000_4444);
      check("R9", "dbg write keeps status", DW'(src_a_pend), 1);
      dbg_wr_en = 1'b1; dbg_idx = 4; dbg_wdata = 32'h5555_5555;
      bus_vld = 1'b1; bus_tag = 7; bus_data = 32'h7777_0007;
      next_cycle();
      dbg_idx = 4; src_a_idx = 4; settle();
      check("R9", "bus beats dbg write", dbg_rdata, 32'h7777_0007);
      check("R5", "bus clears reg4", DW'(src_a_pend), 0);
      next_cycle();
   endtask

   task automatic t_dual_ports();
      ren_en = 1'b1; ren_idx = 8; ren_tag = 12;
      next_cycle();
      src_a_idx = 8; src_b_idx = 8; settle();
      check("R10", "a same reg pend", DW'(src_a_pend), 1);
      check("R10", "b same reg tag", DW'(src_b_tag), 12);
      src_a_idx = 3; src_b_idx = 8; settle();
      check("R10", "a other reg value", src_a_val, 32'hBEEF_0009);
      check("R10", "a other reg pend", DW'(src_a_pend), 0);
      check("R10", "b busy reg pend", DW'(src_b_pend), 1);
      bus_vld = 1'b1; bus_tag = 12; bus_data = 32'h0C0C_0C0C;
      settle();
      check("R10", "b forward value", src_b_val, 32'h0C0C_0C0C);
      check("R10", "b forward pend", DW'(src_b_pend), 0);
      next_cycle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      next_cycle();
      t_reset();
      t_debug_and_lookup();
      t_rename();
      t_stale_result();
      t_match_and_forward();
      t_collide();
      t_debug_on_busy();
      t_dual_ports();
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule